// File: doc/BRIEF.md
# Shadowed Timer Compare Channel

This block is one compare channel beside a free-running timer. Software writes a visible compare register. The value that is actually compared against the timer count lives in a hidden latch. The latch can only be filled from the visible register, and a 2-bit load-mode input chooses the moment of that transfer. The choices are immediately on the write, when the count passes zero, at zero or at the period peak in up/down counting, or when the count reaches the value the latch already holds. This lets software stage a new compare value at any point in a period without producing a glitch in the current period.

The timer counter, its counting mode and the period value (the latch of the period channel) come in as inputs. When the count equals the latched value and the channel is in compare mode, the channel raises a one-clock equality pulse and sets a sticky interrupt flag. The flag stays set until software clears it with a strobe.

Top module: `shadow_cmp_channel`

## Requirements
- R1: While reset is asserted, `irqFlag` and `eqPulse` are 0. Reset clears the visible register, the latch and the pending flag to 0. A count of 0 therefore matches once reset is released.
- R2: With `capMode` = 0, `eqPulse` is 1 for exactly one clock. It rises in the cycle after the first cycle in which `timerCount` equals the latch. A count that stays on the matching value gives no further pulse until the match has ended and begins again.
- R3: `irqFlag` becomes 1 on the same edge as `eqPulse`. It stays 1 until a cycle with `flagClr` = 1. When a new match and `flagClr` fall in the same cycle, the flag ends up set.
- R4: With `capMode` = 1, no equality pulse is produced and the flag is not set. Register writes and latch transfers still take place.
- R5: With `loadSel` = 2'b00, a write (`wrEn` = 1) copies `wrData` into both the visible register and the latch on the same edge. The new value is compared from the next cycle on, and the write leaves the pending flag clear.
- R6: With `loadSel` = 2'b01, a pending value moves into the latch at the edge that ends a cycle with `timerCount` = 0.
- R7: With `loadSel` = 2'b10, a pending value moves into the latch on a cycle with `timerCount` = 0 in every counting mode. When `cntMode` = 2'b11 (up/down), it also moves on a cycle with `timerCount` = `periodVal`. The other `cntMode` codes are 2'b00 halted, 2'b01 up and 2'b10 continuous.
- R8: With `loadSel` = 2'b11, a pending value moves into the latch on a cycle where `timerCount` equals the current latch contents.
- R9: Each write with `loadSel` other than 2'b00 sets the pending flag. A transfer clears it. Without a pending write, no transfer happens. If a write and a load event fall in the same cycle, the latch takes the previous visible value and the flag stays set for the newly written one.
- R10: In a cycle where a match and a transfer coincide, the match is judged against the latch value from before the transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| timerCount | input | CNT_W | Current timer count |
| cntMode | input | 2 | Counting mode: 00 halted, 01 up, 10 continuous, 11 up/down |
| periodVal | input | CNT_W | Period value (period channel latch) |
| capMode | input | 1 | 1 = capture selected, compare inactive |
| wrEn | input | 1 | Write strobe for the visible compare register |
| wrData | input | CNT_W | Write data |
| loadSel | input | 2 | Load mode of the latch |
| flagClr | input | 1 | Clears the interrupt flag |
| irqFlag | output | 1 | Sticky compare interrupt flag |
| eqPulse | output | 1 | One-clock equality pulse |

## Verification
The hardest situation to reach is the one where a transfer and a match fall in the same cycle. The case where a write lands exactly on a load event is just as hard. Both depend on the count's position within the period, the load mode and the write timing together. The bench gets there by sweeping every load mode against every counting mode, with both settings of the compare select and two period values. Under that sweep, pseudo-random writes and clears land on every count value. Per-cycle predictions for the pulse and the flag then expose any transfer that happens early, late or with the wrong value.

// File: rtl/shcmp_pkg.sv
package shcmp_pkg;

  typedef enum logic [1:0] {
    CNT_HALT   = 2'b00,
    CNT_UP     = 2'b01,
    CNT_CONT   = 2'b10,
    CNT_UPDOWN = 2'b11
  } cntMode_e;

  typedef enum logic [1:0] {
    LD_NOW     = 2'b00,
    LD_ZERO    = 2'b01,
    LD_ZERO_PK = 2'b10,
    LD_OWN     = 2'b11
  } ldMode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic wrVis;
    logic latchFromBus;
    logic latchFromVis;
  } dpStrobe_t;

endpackage

// File: rtl/shcmp_datapath.sv
module shcmp_datapath
  import shcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  dpStrobe_t        strb,
  input  logic [CNT_W-1:0] wrData,
  input  logic [CNT_W-1:0] timerCount,
  input  logic [CNT_W-1:0] periodVal,
  output logic             hitLatch,
  output logic             hitZero,
  output logic             hitPeriod
);

  localparam logic [CNT_W-1:0] ZERO_CNT = '0;

  logic [CNT_W-1:0] visReg;
  logic [CNT_W-1:0] cmpLatch;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      visReg <= '0;
    end else if (strb.wrVis) begin
      visReg <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmpLatch <= '0;
    end else if (strb.latchFromBus) begin
      cmpLatch <= wrData;
    end else if (strb.latchFromVis) begin
      cmpLatch <= visReg;
    end
  end

  // comparison uses the registered latch, i.e. the pre-transfer value
  assign hitLatch  = (timerCount == cmpLatch);
  assign hitZero   = (timerCount == ZERO_CNT);
  assign hitPeriod = (timerCount == periodVal);

  // R9
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.latchFromBus || strb.latchFromVis) |=> $stable(cmpLatch));

  // R5
  latch_now_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.latchFromBus |=> (cmpLatch == visReg));

endmodule

// File: rtl/shcmp_ctrl.sv
module shcmp_ctrl
  import shcmp_pkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      capMode,
  input  logic      wrEn,
  input  ldMode_e   ldMode,
  input  cntMode_e  cMode,
  input  logic      flagClr,
  input  logic      hitLatch,
  input  logic      hitZero,
  input  logic      hitPeriod,
  output dpStrobe_t strb,
  output logic      irqFlag,
  output logic      eqPulse
);

  logic pending;
  logic matchNow;
  logic matchPrev;
  logic matchRise;
  logic loadEvt;

  always_comb begin
    unique case (ldMode)
      LD_ZERO:    loadEvt = hitZero;
      LD_ZERO_PK: loadEvt = hitZero || ((cMode == CNT_UPDOWN) && hitPeriod);
      LD_OWN:     loadEvt = hitLatch;
      default:    loadEvt = 1'b0;
    endcase
  end

  always_comb begin
    strb.wrVis        = wrEn;
    strb.latchFromBus = wrEn && (ldMode == LD_NOW);
    strb.latchFromVis = pending && loadEvt && !strb.latchFromBus;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pending <= 1'b0;
    end else if (wrEn) begin
      pending <= (ldMode != LD_NOW);
    end else if (strb.latchFromVis) begin
      pending <= 1'b0;
    end
  end

  assign matchNow  = !capMode && hitLatch;
  assign matchRise = matchNow && !matchPrev;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      matchPrev <= 1'b0;
      eqPulse   <= 1'b0;
      irqFlag   <= 1'b0;
    end else begin
      matchPrev <= matchNow;
      eqPulse   <= matchRise;
      irqFlag   <= matchRise || (irqFlag && !flagClr);
    end
  end

  // R2
  eq_single_chk: assert property (@(posedge clk) disable iff (!rstN)
    eqPulse |=> !eqPulse);

  // R3
  eq_sets_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    eqPulse |-> irqFlag);

  // R3
  flag_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (irqFlag && !flagClr) |=> irqFlag);

  // R4
  cap_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    capMode |=> !eqPulse);

  // R5
  now_no_pend_chk: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && ldMode == LD_NOW) |=> !pending);

  // R9
  pend_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !wrEn && !loadEvt) |=> pending);

endmodule

// File: rtl/shadow_cmp_channel.sv
module shadow_cmp_channel
  import shcmp_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [CNT_W-1:0] timerCount,
  input  logic [1:0]       cntMode,
  input  logic [CNT_W-1:0] periodVal,
  input  logic             capMode,
  input  logic             wrEn,
  input  logic [CNT_W-1:0] wrData,
  input  logic [1:0]       loadSel,
  input  logic             flagClr,
  output logic             irqFlag,
  output logic             eqPulse
);

  dpStrobe_t strb;
  logic      hitLatch;
  logic      hitZero;
  logic      hitPeriod;

  shcmp_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .capMode   (capMode),
    .wrEn      (wrEn),
    .ldMode    (ldMode_e'(loadSel)),
    .cMode     (cntMode_e'(cntMode)),
    .flagClr   (flagClr),
    .hitLatch  (hitLatch),
    .hitZero   (hitZero),
    .hitPeriod (hitPeriod),
    .strb      (strb),
    .irqFlag   (irqFlag),
    .eqPulse   (eqPulse)
  );

  shcmp_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wrData     (wrData),
    .timerCount (timerCount),
    .periodVal  (periodVal),
    .hitLatch   (hitLatch),
    .hitZero    (hitZero),
    .hitPeriod  (hitPeriod)
  );

endmodule

// File: tb/shadow_cmp_channel_test.sv
module shadow_cmp_channel_test;

  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int SEG_CYCLES = 180;

  logic         clk = 1'b0;
  logic         rstN;
  logic [W-1:0] timerCount;
  logic [1:0]   cntMode;
  logic [W-1:0] periodVal;
  logic         capMode;
  logic         wrEn;
  logic [W-1:0] wrData;
  logic [1:0]   loadSel;
  logic         flagClr;
  logic         irqFlag;
  logic         eqPulse;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  // expected-state model, from the requirements
  logic [W-1:0] mVis, mLatch;
  logic         mPend, mPrev, mFlag, mEq;
  logic         upDir;
  logic [15:0]  lfsr = 16'hACE1;

  always #(CLK_PERIOD/2) clk = ~clk;

  shadow_cmp_channel #(.CNT_W(W)) uut (
    .clk(clk), .rstN(rstN), .timerCount(timerCount), .cntMode(cntMode),
    .periodVal(periodVal), .capMode(capMode), .wrEn(wrEn), .wrData(wrData),
    .loadSel(loadSel), .flagClr(flagClr), .irqFlag(irqFlag), .eqPulse(eqPulse)
  );

  task automatic check(input string tag, input logic act, input logic exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s: actual %0b expected %0b (cnt=%0d ld=%0d mode=%0d cap=%0b)",
               tag, act, exp, timerCount, loadSel, cntMode, capMode);
    end
  endtask

  function automatic logic [15:0] nextLfsr(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // one clock: predict, clock, compare
  task automatic stepCycle();
    logic match, evt, doXfer, doBus, coincide;
    string eqTag;
    match = !capMode && (timerCount == mLatch);
    case (loadSel)
      2'b01:   evt = (timerCount == 0);
      2'b10:   evt = (timerCount == 0) || (cntMode == 2'b11 && timerCount == periodVal);
      2'b11:   evt = (timerCount == mLatch);
      default: evt = 1'b0;
    endcase
    doBus    = wrEn && loadSel == 2'b00;
    doXfer   = mPend && evt && !doBus;
    coincide = match && doXfer;
    mEq   = match && !mPrev;
    mFlag = mEq || (mFlag && !flagClr);
    mPrev = match;
    if (doBus) mLatch = wrData;
    else if (doXfer) mLatch = mVis;
    if (wrEn) begin
      mVis  = wrData;
      mPend = (loadSel != 2'b00);
    end else if (doXfer) mPend = 1'b0;
    case (loadSel)
      2'b00:   eqTag = "R2 R5";
      2'b01:   eqTag = "R2 R6";
      2'b10:   eqTag = "R2 R7";
      default: eqTag = "R2 R8";
    endcase
    if (capMode) eqTag = {eqTag, " R4"};
    if (doXfer) eqTag = {eqTag, " R9"};
    if (coincide) eqTag = {eqTag, " R10"};
    @(posedge clk);
    #1;
    check(eqTag, eqPulse, mEq);
    check(capMode ? "R3 R4" : "R3", irqFlag, mFlag);
  endtask

  function automatic logic [W-1:0] advance(input logic [W-1:0] c);
    logic [W-1:0] n;
    case (cntMode)
      2'b01: n = (c >= periodVal) ? '0 : c + 1'b1;
      2'b10: n = c + 1'b1;
      2'b11: begin
        if (upDir) begin
          if (c >= periodVal) begin upDir = 1'b0; n = c - 1'b1; end
          else n = c + 1'b1;
        end else begin
          if (c == 0) begin upDir = 1'b1; n = c + 1'b1; end
          else n = c - 1'b1;
        end
      end
      default: n = c;
    endcase
    return n;
  endfunction

  initial begin
    rstN = 1'b0; timerCount = '0; cntMode = 2'b01; periodVal = 4'd11;
    capMode = 1'b1; wrEn = 1'b0; wrData = '0; loadSel = 2'b00; flagClr = 1'b0;
    mVis = '0; mLatch = '0; mPend = 1'b0; mPrev = 1'b0; mFlag = 1'b0; mEq = 1'b0;
    upDir = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check("R1", irqFlag, 1'b0);
    check("R1", eqPulse, 1'b0);
    rstN = 1'b1;
    capMode = 1'b0;
    // latch is 0 after reset, so count 0 matches at once
    stepCycle();
    check("R1", eqPulse, 1'b1);
    for (int p = 0; p < 2; p++) begin
      for (int cap = 0; cap < 2; cap++) begin
        for (int ld = 0; ld < 4; ld++) begin
          for (int md = 0; md < 4; md++) begin
            periodVal = (p == 0) ? 4'd11 : 4'd5;
            capMode = cap[0];
            loadSel = ld[1:0];
            cntMode = md[1:0];
            timerCount = '0;
            upDir = 1'b1;
            for (int i = 0; i < SEG_CYCLES; i++) begin
              lfsr = nextLfsr(lfsr);
              wrEn = (lfsr[2:0] == 3'd0);
              wrData = lfsr[8:5];
              flagClr = (lfsr[12:10] == 3'd3);
              stepCycle();
              timerCount = advance(timerCount);
            end
          end
        end
      end
    end
    wrEn = 1'b0; flagClr = 1'b0;
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    finished = 1;
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

endmodule